// File: doc/BRIEF.md
# Least-Recently-Granted Matrix Arbiter

This block picks a single winner among `NREQ` requesters in each cycle. Their relative standing is kept as a pairwise ordering. For any two requesters, one bit records which of the two currently outranks the other. A requester wins when it is asking and no requester that outranks it is also asking. The grant is combinational, so it is seen in the same cycle as the request vector.

When the consumer accepts the grant by raising `advance`, the ordering is rewritten so that the winner falls below every other requester. The order then always ranks requesters by how long ago each was last served. The one served longest ago is on top.

Only the pairs above the diagonal are stored. The opposite relation of each pair is its complement. The reset input clears the ordering at once. Its release is synchronised to the clock. After reset the lower index outranks the higher.

Top module: `matrix_arbiter`

## Requirements
- R1: `grant` has at most one bit set, and it is non-zero whenever at least one `req` bit is set.
- R2: A `grant` bit is set only for a requester whose `req` bit is set.
- R3: After reset, and until the first accepted grant, requester i outranks requester j exactly when i < j. Bit 0 of the vectors is requester 0.
- R4: The granted requester is the asking one that was accepted least recently. Among asking requesters that were never accepted since reset, the lowest index wins.
- R5: When `grant` is non-zero and `advance` is 1 at a rising clock edge, the winner ranks below every other requester from the next cycle on.
- R6: When `advance` is 0 at a clock edge, the ordering is unchanged whatever `req` is.
- R7: When `req` is all zeros, `grant` is all zeros and the ordering is unchanged even with `advance` at 1.
- R8: `grant` depends combinationally on `req` in the same cycle, with no register between them.
- R9: Driving `rst_n` low returns the ordering to index order immediately, with no clock needed, even in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| req | input | NREQ | One request bit per requester |
| advance | input | 1 | Accepts the current grant and lets the ordering update |
| grant | output | NREQ | One-hot grant, or zero when nothing is requested |

## Verification
The bench keeps an ordered queue of requester indices and compares `grant` with it in every cycle. It targets these failures:
- A design that moves the winner while `advance` is low would later give a grant out of turn.
- A design that updates on an empty request cycle would corrupt the order, for example if it treats a zero grant as a grant to requester 0.
- A design that reads the lower triangle without complementing would show two grants at once, or none.
- A reset taken mid-run must restore index order. Stale ordering bits would then pick the wrong requester when all of them ask together.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Flat position of pair (hi, lo) with hi < lo in the stored upper triangle
  function automatic int tri_pos(input int n, input int hi, input int lo);
    return hi * n - (hi * (hi + 1)) / 2 + (lo - hi - 1);
  endfunction
endpackage

// File: rtl/arb_reset_sync.sv
module arb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/arb_order_matrix.sv
module arb_order_matrix
  import arb_pkg::*;
#(
  parameter int NREQ = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [NREQ-1:0]      winner,
  output logic [NREQ*NREQ-1:0] outranks   // [a*NREQ+b] = a outranks b
);
  localparam int NPAIR = NREQ * (NREQ - 1) / 2;

  logic [NPAIR-1:0] pair_q;
  logic [NPAIR-1:0] pair_d;

  always_comb begin
    pair_d = pair_q;
    if (upd_en) begin
      for (int a = 0; a < NREQ; a++) begin
        for (int b = a + 1; b < NREQ; b++) begin
          if (winner[a])      pair_d[tri_pos(NREQ, a, b)] = 1'b0;
          else if (winner[b]) pair_d[tri_pos(NREQ, a, b)] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pair_q <= '1;
    else if (upd_en) pair_q <= pair_d;
  end

  for (genvar a = 0; a < NREQ; a++) begin : g_row
    for (genvar b = 0; b < NREQ; b++) begin : g_col
      if (a < b) begin : g_up
        assign outranks[a*NREQ+b] = pair_q[tri_pos(NREQ, a, b)];
      end else if (a > b) begin : g_lo
        assign outranks[a*NREQ+b] = ~pair_q[tri_pos(NREQ, b, a)];
      end else begin : g_dg
        assign outranks[a*NREQ+b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/arb_grant_logic.sv
module arb_grant_logic #(
  parameter int NREQ = 4
) (
  input  logic [NREQ-1:0]      req,
  input  logic [NREQ*NREQ-1:0] outranks,
  output logic [NREQ-1:0]      grant
);
  logic [NREQ-1:0] blocked;

  always_comb begin
    for (int v = 0; v < NREQ; v++) begin
      blocked[v] = 1'b0;
      for (int o = 0; o < NREQ; o++) begin
        if (req[o] && outranks[o*NREQ+v]) blocked[v] = 1'b1;
      end
    end
    grant = req & ~blocked;
  end
endmodule

// File: rtl/matrix_arbiter.sv
module matrix_arbiter #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            advance,
  output logic [NREQ-1:0] grant
);
  logic                 rst_q;
  logic                 upd_en;
  logic [NREQ*NREQ-1:0] outranks;

  arb_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  arb_order_matrix #(.NREQ(NREQ)) u_mtx (
    .clk      (clk),
    .rst_n    (rst_q),
    .upd_en   (upd_en),
    .winner   (grant),
    .outranks (outranks)
  );

  arb_grant_logic #(.NREQ(NREQ)) u_gnt (
    .req      (req),
    .outranks (outranks),
    .grant    (grant)
  );

  assign upd_en = advance & (|grant);
endmodule

// File: rtl/matrix_arbiter_checker.sv
module matrix_arbiter_checker #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_q,
  input logic [NREQ-1:0] req,
  input logic            advance,
  input logic [NREQ-1:0] grant
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(grant));                                              // R1
  AST_GRANT_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_q)
    (|req) |-> (|grant));                                          // R1
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_q)
    (grant & ~req) == '0);                                         // R2
  AST_HOLD_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_q)
    (seen_q && !$past(advance) && $stable(req)) |-> $stable(grant)); // R6
  AST_WINNER_DROPS: assert property (@(posedge clk) disable iff (!rst_q)
    (seen_q && advance && $countones(req) > 1)
      |=> (req != $past(req)) || (grant != $past(grant)));         // R5
endmodule

bind matrix_arbiter matrix_arbiter_checker #(.NREQ(NREQ)) u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .req     (req),
  .advance (advance),
  .grant   (grant)
);

// File: tb/test_matrix_arbiter.sv
module test_matrix_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         advance = 1'b0;
  logic [N-1:0] grant;

  int total = 0;
  int fails = 0;
  int order[$];

  always #2.5 clk = ~clk;

  matrix_arbiter #(.NREQ(N)) i_matrix_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .advance(advance), .grant(grant)
  );

  function automatic logic [N-1:0] expect_grant(input logic [N-1:0] r);
    for (int k = 0; k < order.size(); k++)
      if (r[order[k]]) return N'(1) << order[k];
    return '0;
  endfunction

  task automatic model_reset();
    order = {};
    for (int k = 0; k < N; k++) order.push_back(k);
  endtask

  task automatic check(input string tag, input logic ok,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: grant actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic adv, input string tag);
    logic [N-1:0] exp;
    @(negedge clk);
    req = r; advance = adv;
    #1;
    exp = expect_grant(r);
    check(tag, grant === exp, grant, exp);
    @(posedge clk);
    if (adv && exp != '0) begin
      for (int k = 0; k < order.size(); k++)
        if (exp[order[k]]) begin
          int w = order[k];
          order.delete(k);
          order.push_back(w);
          break;
        end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; advance = 1'b0; req = '1;
    model_reset();
    #1;
    check("R9 async reset order", grant === 4'b0001, grant, 4'b0001);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total + 1 - fails, total + 1);
    $finish;
  end

  initial begin
    do_reset();
    step('0, 1'b0, "R7 idle reset state");
    step(4'b1111, 1'b0, "R3 index order after reset");
    step(4'b1110, 1'b0, "R3 next index wins");
    step(4'b1100, 1'b0, "R8 same-cycle grant");
    // round robin with all asking
    for (int k = 0; k < 8; k++) step(4'b1111, 1'b1, "R4 rotation all asking");
    // advance low must not move anyone
    step(4'b0110, 1'b0, "R6 hold");
    step(4'b0110, 1'b0, "R6 hold repeat");
    step(4'b1111, 1'b0, "R6 order kept");
    // empty requests with advance high
    step('0, 1'b1, "R7 empty with advance");
    step(4'b1111, 1'b1, "R7 order kept after empty");
    // winner drops below others
    step(4'b1001, 1'b1, "R5 pair first");
    step(4'b1001, 1'b1, "R5 pair second");
    step(4'b1001, 1'b1, "R5 pair swap back");
    // single requester never blocked
    for (int k = 0; k < N; k++) step(N'(1) << k, 1'b1, "R2 lone requester");
    // random traffic
    for (int k = 0; k < 300; k++)
      step(N'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), "R1 random traffic");
    // reset in mid-run
    do_reset();
    step(4'b1111, 1'b1, "R9 order after mid-run reset");
    step(4'b1010, 1'b1, "R4 after reset");
    for (int k = 0; k < 100; k++)
      step(N'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), "R4 random after reset");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule